// File: doc/BRIEF.md
# Ripple-Through Strobe FIFO

This block is a first-in first-out buffer of DEPTH words, each WIDTH bits wide (64 by 9 by default). It is not built around pointers or a fill counter. It is a chain of stages, and each stage carries one occupied bit and one data word. A word written at the input stage travels toward the output stage one position per step and stops behind the last occupied stage. When the output stage is unloaded, the freed slot travels backward toward the input in the same way, one position per step.

A producer writes by raising the shift-in strobe while the input-ready flag is high. The word is taken on that clock edge, and the input-ready flag then reads low until the input stage has emptied again. A consumer reads the output word whenever the output-ready flag is high and raises the shift-out strobe to remove it. The parameter STEP_CYCLES sets how many clock cycles one step of travel takes, and so sets the fall-through and bubble-back latency.

Top module: `ripple_fifo`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, `in_rdy` is 1 and `out_rdy` is 0.
- R2: `in_rdy` is 1 exactly when the input stage holds no word. A capture makes it 0 on the next cycle. With STEP_CYCLES=1 and stage 1 free, it returns to 1 one cycle after that.
- R3: A capture needs `shift_in` to have been sampled low since the previous capture. Holding `shift_in` high loads a single word, whatever happens on `din` during that time.
- R4: With STEP_CYCLES=1 and an empty buffer, `out_rdy` rises DEPTH-1 clock edges after the capture edge, and `dout` then holds the written word.
- R5: Words leave in the order they were written. `dout` stays stable while `out_rdy` is 1 and no shift-out occurs.
- R6: When all DEPTH stages are occupied, `in_rdy` stays 0, and a shift-in pulse loads no data. Exactly DEPTH words can be read back afterwards.
- R7: A rising `shift_out` while `out_rdy` is 1 removes the output word. `out_rdy` is 0 on the next cycle.
- R8: A rising `shift_out` while `out_rdy` is 0 changes nothing: no word is lost and no flag changes.
- R9: From full with STEP_CYCLES=1, `in_rdy` rises DEPTH-1 edges after the shift-out edge. If `shift_in` was held high waiting, the word is captured on the next edge and `in_rdy` is 0 again.
- R10: With STEP_CYCLES=S, a word advances one stage per S cycles. Fall-through from an empty buffer takes between S*(DEPTH-2)+1 and S*(DEPTH-1) edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| shift_in | input | 1 | Write strobe; a capture needs a low phase before it |
| din | input | WIDTH | Word to write |
| in_rdy | output | 1 | High when the input stage is free |
| shift_out | input | 1 | Read strobe; acts on its rising edge |
| dout | output | WIDTH | Word in the output stage |
| out_rdy | output | 1 | High when the output stage holds a word |

## Verification
The properties assume that both strobes are synchronous to `clk` and that `din` is valid whenever `shift_in` is high with `in_rdy` high. They also assume that no strobe activity during reset needs to be remembered. The bench drives every input on the falling clock edge. It drops each strobe to low for at least one rising edge between operations, and during reset it holds both strobes low. Holding `shift_in` high across many cycles is done on purpose, to exercise the arming rule and the wait on a full buffer.

// File: rtl/rfifo_pkg.sv
package rfifo_pkg;

  // A word may leave a stage when it has one, the next stage is free,
  // and the pace generator allows a step in this cycle.
  function automatic logic can_advance(input logic here_full,
                                       input logic ahead_full,
                                       input logic step_ok);
    return here_full && !ahead_full && step_ok;
  endfunction

  // Modulo counter increment used by the pace generator.
  function automatic int unsigned wrap_inc(input int unsigned v,
                                           input int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

  // Width of a counter that reaches lim-1 (at least one bit).
  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim > 1) ? $clog2(lim) : 1;
  endfunction

endpackage

// File: rtl/rfifo_pace.sv
module rfifo_pace
  import rfifo_pkg::*;
#(
  parameter int STEP_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic step
);
  localparam int CW = int'(cnt_width(STEP_CYCLES));
  localparam logic [CW-1:0] LAST_PHASE = CW'(STEP_CYCLES - 1);

  logic [CW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= CW'(wrap_inc(32'(phase), 32'(STEP_CYCLES)));
  end

  assign step = (phase == LAST_PHASE);
endmodule

// File: rtl/rfifo_strobe.sv
module rfifo_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_in,
  input  logic shift_out,
  input  logic in_busy,
  input  logic out_full,
  output logic cap,
  output logic take
);
  logic in_armed;
  logic so_q;

  // Write side: armed by a low strobe, consumed by a capture.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         in_armed <= 1'b0;
    else if (cap)       in_armed <= 1'b0;
    else if (!shift_in) in_armed <= 1'b1;
  end

  // Read side: rising-edge detector, reset high so a level held
  // through reset is not taken as an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) so_q <= 1'b1;
    else        so_q <= shift_out;
  end

  assign cap  = shift_in && in_armed && !in_busy;
  assign take = shift_out && !so_q && out_full;
endmodule

// File: rtl/rfifo_stage.sv
module rfifo_stage #(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             unload,
  input  logic [WIDTH-1:0] d_in,
  output logic             occ,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      occ <= 1'b0;
    else if (load)   occ <= 1'b1;
    else if (unload) occ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d_in;
  end
endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo
  import rfifo_pkg::*;
#(
  parameter int WIDTH       = 9,
  parameter int DEPTH       = 64,
  parameter int STEP_CYCLES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] din,
  output logic             in_rdy,
  input  logic             shift_out,
  output logic [WIDTH-1:0] dout,
  output logic             out_rdy
);
  localparam int LAST = DEPTH - 1;

  // Named internal events, visible to the bound checker.
  logic             step;
  logic             cap;
  logic             take;
  logic [DEPTH-1:0] occ;
  logic [DEPTH-1:0] adv;
  logic [WIDTH-1:0] stg_q [DEPTH];

  rfifo_pace #(.STEP_CYCLES(STEP_CYCLES)) u_pace (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step)
  );

  rfifo_strobe u_strobe (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_in  (shift_in),
    .shift_out (shift_out),
    .in_busy   (occ[0]),
    .out_full  (occ[LAST]),
    .cap       (cap),
    .take      (take)
  );

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    logic             ld;
    logic [WIDTH-1:0] src;

    if (k == 0) begin : g_head
      assign ld  = cap;
      assign src = din;
    end else begin : g_body
      assign ld  = adv[k-1];
      assign src = stg_q[k-1];
    end

    if (k < LAST) begin : g_fwd
      assign adv[k] = can_advance(occ[k], occ[k+1], step);
    end else begin : g_tail
      assign adv[k] = take;
    end

    rfifo_stage #(.WIDTH(WIDTH)) u_stg (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (ld),
      .unload (adv[k]),
      .d_in   (src),
      .occ    (occ[k]),
      .q      (stg_q[k])
    );
  end

  assign in_rdy  = ~occ[0];
  assign out_rdy = occ[LAST];
  assign dout    = stg_q[LAST];
endmodule

// File: rtl/rfifo_chk.sv
module rfifo_chk #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shift_out,
  input logic             in_rdy,
  input logic             out_rdy,
  input logic [WIDTH-1:0] dout,
  input logic             cap,
  input logic             take,
  input logic [DEPTH-1:0] occ
);
  AST_RESET_FLAGS: assert property (@(posedge clk) !rst_n |=> (in_rdy && !out_rdy)); // R1
  AST_CAP_BUSY: assert property (@(posedge clk) disable iff (!rst_n) cap |=> !in_rdy); // R2
  AST_ONE_LOAD_PER_HIGH: assert property (@(posedge clk) disable iff (!rst_n) cap |=> !cap); // R3
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n) (out_rdy && !take) |=> (out_rdy && $stable(dout))); // R5
  AST_WORD_COUNT: assert property (@(posedge clk) disable iff (!rst_n) $countones(occ) == $past($countones(occ)) + int'($past(cap)) - int'($past(take))); // R6
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (&occ && !take) |=> &occ); // R6
  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) take |=> !out_rdy); // R7
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n) (shift_out && !out_rdy) |=> $countones(occ) >= $past($countones(occ))); // R8
endmodule

bind ripple_fifo rfifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .shift_out (shift_out),
  .in_rdy    (in_rdy),
  .out_rdy   (out_rdy),
  .dout      (dout),
  .cap       (cap),
  .take      (take),
  .occ       (occ)
);

// File: tb/sim_ripple_fifo.sv
module sim_ripple_fifo;
  localparam int W     = 9;
  localparam int D     = 64;
  localparam int SLOW  = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         si, so, si1, so1;
  logic [W-1:0] din;
  logic         dir, dor, dir1, dor1;
  logic [W-1:0] dout, dout1;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [W-1:0] exp_q [$];

  always #5 clk = ~clk;

  ripple_fifo #(.WIDTH(W), .DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .shift_in(si), .din(din), .in_rdy(dir),
    .shift_out(so), .dout(dout), .out_rdy(dor)
  );

  ripple_fifo #(.WIDTH(W), .DEPTH(D), .STEP_CYCLES(SLOW)) u1 (
    .clk(clk), .rst_n(rst_n), .shift_in(si1), .din(din), .in_rdy(dir1),
    .shift_out(so1), .dout(dout1), .out_rdy(dor1)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Driver: writes one word and records it in the scoreboard.
  task automatic push_word(input logic [W-1:0] d);
    while (!dir) @(negedge clk);
    din = d;
    si  = 1'b1;
    @(negedge clk);
    exp_q.push_back(d);
    chk(dir == 1'b0, "R2", "in_rdy after capture", int'(dir), 0);
    si = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: waits for a word, compares it against the scoreboard, removes it.
  task automatic pop_word();
    logic [W-1:0] e;
    while (!dor) @(negedge clk);
    if (exp_q.size() == 0) begin
      chk(1'b0, "R5", "unexpected word", int'(dout), -1);
    end else begin
      e = exp_q.pop_front();
      chk(dout == e, "R5", "output order", int'(dout), int'(e));
    end
    so = 1'b1;
    @(negedge clk);
    chk(dor == 1'b0, "R7", "out_rdy after shift-out", int'(dor), 0);
    so = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; si = 1'b0; so = 1'b0; si1 = 1'b0; so1 = 1'b0; din = '0;
    tick(3);
    // R1: flags during reset
    chk(dir == 1'b1, "R1", "in_rdy in reset", int'(dir), 1);
    chk(dor == 1'b0, "R1", "out_rdy in reset", int'(dor), 0);
    chk(dir1 == 1'b1, "R1", "slow in_rdy in reset", int'(dir1), 1);
    rst_n = 1'b1;
    tick(3);

    // R10: slow pacing fall-through window
    din = 9'h1A5; si1 = 1'b1;
    @(negedge clk);
    si1 = 1'b0;
    n = 0;
    while (!dor1 && n < 1000) begin @(negedge clk); n++; end
    chk(n >= SLOW*(D-2)+1 && n <= SLOW*(D-1), "R10", "slow fall-through edges", n, SLOW*(D-1));
    chk(dout1 == 9'h1A5, "R10", "slow output word", int'(dout1), 'h1A5);

    // R4 / R2: fall-through timing on the fast instance
    push_word(9'h055);
    chk(dir == 1'b1, "R2", "in_rdy back after one step", int'(dir), 1);
    n = 1;
    while (!dor && n < 1000) begin @(negedge clk); n++; end
    chk(n == D-1, "R4", "fall-through edges", n, D-1);
    chk(dout == 9'h055, "R4", "fallen word", int'(dout), 'h055);
    pop_word();

    // R8: shift-out on empty, then during fall-through
    so = 1'b1; @(negedge clk); so = 1'b0; @(negedge clk);
    chk(dir == 1'b1 && dor == 1'b0, "R8", "flags after idle read", int'({dir, dor}), 2);
    push_word(9'h0F0);
    tick(5);
    so = 1'b1; @(negedge clk); so = 1'b0; @(negedge clk);
    pop_word();
    chk(exp_q.size() == 0, "R8", "word kept through idle read", exp_q.size(), 0);

    // R3: strobe held high loads one word only
    din = 9'h101; si = 1'b1;
    @(negedge clk);
    exp_q.push_back(9'h101);
    for (int i = 0; i < 8; i++) begin din = 9'(9'h110 + i); @(negedge clk); end
    si = 1'b0;
    @(negedge clk);
    push_word(9'h102);
    pop_word();
    pop_word();
    tick(D + 5);
    chk(dor == 1'b0, "R3", "no extra word after held strobe", int'(dor), 0);

    // R6: fill to full, then a rejected write
    for (int i = 0; i < D; i++) push_word(9'((i * 7 + 3) % 512));
    tick(D + 2);
    chk(dir == 1'b0, "R6", "in_rdy when full", int'(dir), 0);
    chk(dor == 1'b1, "R6", "out_rdy when full", int'(dor), 1);
    din = 9'h1FF; si = 1'b1; @(negedge clk); si = 1'b0; @(negedge clk);
    tick(D + 2);
    chk(dir == 1'b0, "R6", "in_rdy after rejected write", int'(dir), 0);

    // R9: waiting write catches the bubbled-up vacancy
    din = 9'h0AA; si = 1'b1;
    @(negedge clk);
    pop_word();
    n = 1;
    while (!dir && n < 1000) begin @(negedge clk); n++; end
    chk(n == D-1, "R9", "bubble-up edges", n, D-1);
    @(negedge clk);
    exp_q.push_back(9'h0AA);
    chk(dir == 1'b0, "R9", "in_rdy after waiting capture", int'(dir), 0);
    si = 1'b0;
    tick(3);
    chk(dir == 1'b0, "R9", "in_rdy stays low, full again", int'(dir), 0);

    // drain everything, R5 order and R6 count
    for (int i = 0; i < D; i++) pop_word();
    tick(D + 3);
    chk(dor == 1'b0, "R6", "no word beyond capacity", int'(dor), 0);
    chk(dir == 1'b1, "R6", "in_rdy when drained", int'(dir), 1);
    chk(exp_q.size() == 0, "R5", "scoreboard empty", exp_q.size(), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule